// File: doc/BRIEF.md
# Locked Clock Configuration Register File

This block is a peripheral-bus slave that holds a small set of system control registers. Three of these registers set the clock generators: each is a 19-bit divisor word with an output-divider select, a VCO divider word and a reference divider word. These three registers are protected by a key. They accept a write only while a 16-bit magic value is held in the lock register. Any other value in the lock register makes writes to them vanish without an error. The lock register reports the derived lock state in a read-only bit above the key field.

The other registers hold the user LED drive, a latched push-button flag that software can set or clear, the live switch inputs, two 32-bit transfer addresses and a write-data word for the bus-master logic, and a read-only word that captures the data returned by the most recent master read. All register values go out on plain output pins. The captured read data arrives on a valid/ready stream input. That input never applies back-pressure: `cap_ready` is held high, and each beat with `cap_valid` high is taken at the clock edge.

Accesses have no wait states and never return an error. A write takes effect at the clock edge that ends its access phase. Read data is driven combinationally during the access phase and is decoded from byte address bits [ADDR_W-1:2]. Address bits [1:0] are ignored.

Top module: `clkcfg_regfile`

## Requirements
- R1: After reset, every divisor register reads 0x00002C70 (select 3'b000, VCO word 7'b0010110, reference word 9'b001110000), the lock register reads 0x00010000, and the LED, button, write-data and read-data registers read zero.
- R2: A divisor register (offsets 0x00, 0x04, 0x08) written while unlocked takes pwdata[18:0]. It holds the select in [18:16], the VCO word in [15:9] and the reference word in [8:0]. Bits [31:19] read as zero. Divisor k appears on div_cfg_o[19k+18:19k].
- R3: A write to a divisor register while locked leaves its value and its div_cfg_o field unchanged, and the access completes with pready=1 and pslverr=0.
- R4: The lock register (0x0C) stores pwdata[15:0] and reads it back in [15:0]. Bit 16 reads 0 exactly when the stored key equals 0xA05F and 1 otherwise. Bits [31:17] read as zero.
- R5: The LED register (0x10) stores pwdata[LED_W-1:0], reads it back with the upper bits zero, and drives led_o.
- R6: The button flag (0x18, bit 0) is set by a high btn_press at a clock edge. Writing bit 0 as 0 clears it and writing it as 1 sets it. A press in the same cycle as a clearing write leaves it set. The flag drives btn_flag_o.
- R7: The switch register (0x1C) reads sw_in in its low SW_W bits, and writes to it have no effect.
- R8: The transfer-address registers at 0x24 and 0x28 reset to 0x04000000 and 0x04000004. Both are 32-bit read/write and drive mst_addr0_o and mst_addr1_o.
- R9: The write-data register (0x14) is 32-bit read/write and drives mst_wdata_o. The read-data register (0x20) captures cap_data on each clock edge with cap_valid high, and ignores bus writes.
- R10: Reads of offsets 0x2C and above return zero. Every access completes in its access phase with pready=1 and pslverr=0.
- R11: cap_ready is always 1, so no captured beat is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| btn_press | input | 1 | Push-button press, sampled each edge |
| sw_in | input | SW_W | Switch levels |
| cap_valid | input | 1 | Captured master read data valid |
| cap_ready | output | 1 | Always 1 |
| cap_data | input | 32 | Captured master read data |
| div_cfg_o | output | 3*19 | The three divisor words, packed |
| led_o | output | LED_W | LED drive |
| btn_flag_o | output | 1 | Latched button flag |
| mst_addr0_o | output | 32 | Transfer address, master 0 |
| mst_addr1_o | output | 32 | Transfer address, master 1 |
| mst_wdata_o | output | 32 | Data for the next master write |

## Verification
Divisor writes are tried locked, unlocked and after relocking. One key write carries junk in its upper half, which shows that only bits [15:0] take part in the key compare. All-ones and mixed-field divisor data show the field packing and that bits above 18 are dropped. The button flag is driven by a press alone, by software set and clear, and by a press that lands in the same cycle as a clear, which tells the two sources' priority apart. Writes to the switch and captured-data offsets, and reads past the last register, show that read-only and unmapped words cannot be disturbed.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 19;
  localparam int N_DIV  = 3;
  localparam int KEY_W  = 16;

  // Word indices (byte offset / 4); the bus-visible offsets are fixed.
  localparam int IX_DIV0 = 0;
  localparam int IX_LOCK = 3;
  localparam int IX_LED  = 4;
  localparam int IX_WDAT = 5;
  localparam int IX_BTN  = 6;
  localparam int IX_SW   = 7;
  localparam int IX_RDAT = 8;
  localparam int IX_MA0  = 9;
  localparam int IX_MA1  = 10;
  localparam int N_REGS  = 11;

  typedef struct packed {
    logic [2:0] out_sel;
    logic [6:0] vco_word;
    logic [8:0] ref_word;
  } div_t;

  localparam div_t DIV_RST = '{out_sel: 3'b000, vco_word: 7'b0010110,
                               ref_word: 9'b001110000};
  localparam logic [KEY_W-1:0]  UNLOCK_KEY = 16'hA05F;
  localparam logic [DATA_W-1:0] MA0_RST    = 32'h0400_0000;
  localparam logic [DATA_W-1:0] MA1_RST    = 32'h0400_0004;
endpackage

// File: rtl/regfile_apb_decode.sv
module regfile_apb_decode #(
  parameter int ADDR_W = 8,
  parameter int N_REGS = 11,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic [N_REGS-1:0] wr_hit,
  output logic [N_REGS-1:0] rd_sel
);
  logic [IDX_W-1:0] word_idx;
  logic             access;

  assign word_idx = paddr[ADDR_W-1:2];
  assign access   = psel & penable;

  for (genvar i = 0; i < N_REGS; i++) begin : g_hit
    logic match;
    assign match     = (word_idx == IDX_W'(i));
    assign wr_hit[i] = access & pwrite & match;
    assign rd_sel[i] = match;
  end
endmodule

// File: rtl/regfile_div_lock.sv
module regfile_div_lock
  import clkcfg_pkg::*;
#(
  parameter int NDIV = N_DIV
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lock_wr,
  input  logic [NDIV-1:0]          div_wr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [KEY_W-1:0]         key_q,
  output logic                     locked,
  output logic [NDIV-1:0][DIV_W-1:0] div_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       key_q <= '0;
    else if (lock_wr) key_q <= wdata[KEY_W-1:0];
  end

  assign locked = (key_q != UNLOCK_KEY);

  for (genvar k = 0; k < NDIV; k++) begin : g_div
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    div_q[k] <= DIV_RST;
      else if (div_wr[k] && !locked) div_q[k] <= wdata[DIV_W-1:0];
    end

    // R3: a locked bank keeps every divisor word
    p_div_hold_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(div_q[k]));
  end

  // R4: the key field follows the last lock write
  p_key_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr |=> (key_q == $past(wdata[KEY_W-1:0])));
endmodule

// File: rtl/regfile_ctl_regs.sv
module regfile_ctl_regs
  import clkcfg_pkg::*;
#(
  parameter int LED_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              led_wr,
  input  logic              btn_wr,
  input  logic              wdat_wr,
  input  logic              ma0_wr,
  input  logic              ma1_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              btn_press,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  output logic [LED_W-1:0]  led_q,
  output logic              btn_q,
  output logic [DATA_W-1:0] wdat_q,
  output logic [DATA_W-1:0] rdat_q,
  output logic [DATA_W-1:0] ma0_q,
  output logic [DATA_W-1:0] ma1_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q  <= '0;
      wdat_q <= '0;
      ma0_q  <= MA0_RST;
      ma1_q  <= MA1_RST;
    end else begin
      if (led_wr)  led_q  <= wdata[LED_W-1:0];
      if (wdat_wr) wdat_q <= wdata;
      if (ma0_wr)  ma0_q  <= wdata;
      if (ma1_wr)  ma1_q  <= wdata;
    end
  end

  // A press outranks a clearing write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         btn_q <= 1'b0;
    else if (btn_press) btn_q <= 1'b1;
    else if (btn_wr)    btn_q <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdat_q <= '0;
    else if (cap_valid) rdat_q <= cap_data;
  end

  // R6: a press always leaves the flag set
  p_btn_press_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    btn_press |=> btn_q);

  // R9: a captured beat lands in the read-data word
  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> (rdat_q == $past(cap_data)));

  // R8: transfer addresses move only on their own writes
  p_ma0_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ma0_wr |=> $stable(ma0_q));
endmodule

// File: rtl/regfile_rd_mux.sv
module regfile_rd_mux
  import clkcfg_pkg::*;
#(
  parameter int NREG = N_REGS
) (
  input  logic [NREG-1:0]             rd_sel,
  input  logic [NREG-1:0][DATA_W-1:0] words,
  output logic [DATA_W-1:0]           rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_sel[i]) rdata = rdata | words[i];
    end
  end
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
  import clkcfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LED_W  = 8,
  parameter int SW_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [ADDR_W-1:0]       paddr,
  input  logic [31:0]             pwdata,
  output logic [31:0]             prdata,
  output logic                    pready,
  output logic                    pslverr,
  input  logic                    btn_press,
  input  logic [SW_W-1:0]         sw_in,
  input  logic                    cap_valid,
  output logic                    cap_ready,
  input  logic [31:0]             cap_data,
  output logic [3*19-1:0]         div_cfg_o,
  output logic [LED_W-1:0]        led_o,
  output logic                    btn_flag_o,
  output logic [31:0]             mst_addr0_o,
  output logic [31:0]             mst_addr1_o,
  output logic [31:0]             mst_wdata_o
);
  logic [N_REGS-1:0]             wr_hit;
  logic [N_REGS-1:0]             rd_sel;
  logic [KEY_W-1:0]              key_q;
  logic                          locked;
  logic [N_DIV-1:0][DIV_W-1:0]   div_q;
  logic [LED_W-1:0]              led_q;
  logic                          btn_q;
  logic [DATA_W-1:0]             wdat_q, rdat_q, ma0_q, ma1_q;
  logic [N_REGS-1:0][DATA_W-1:0] words;

  regfile_apb_decode #(.ADDR_W(ADDR_W), .N_REGS(N_REGS)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .wr_hit(wr_hit), .rd_sel(rd_sel));

  regfile_div_lock #(.NDIV(N_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .lock_wr(wr_hit[IX_LOCK]),
    .div_wr(wr_hit[IX_DIV0 +: N_DIV]), .wdata(pwdata),
    .key_q(key_q), .locked(locked), .div_q(div_q));

  regfile_ctl_regs #(.LED_W(LED_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .led_wr(wr_hit[IX_LED]), .btn_wr(wr_hit[IX_BTN]), .wdat_wr(wr_hit[IX_WDAT]),
    .ma0_wr(wr_hit[IX_MA0]), .ma1_wr(wr_hit[IX_MA1]), .wdata(pwdata),
    .btn_press(btn_press), .cap_valid(cap_valid), .cap_data(cap_data),
    .led_q(led_q), .btn_q(btn_q), .wdat_q(wdat_q), .rdat_q(rdat_q),
    .ma0_q(ma0_q), .ma1_q(ma1_q));

  for (genvar k = 0; k < N_DIV; k++) begin : g_divword
    assign words[IX_DIV0+k] = DATA_W'(div_q[k]);
    assign div_cfg_o[k*DIV_W +: DIV_W] = div_q[k];
  end
  assign words[IX_LOCK] = DATA_W'({locked, key_q});
  assign words[IX_LED]  = DATA_W'(led_q);
  assign words[IX_WDAT] = wdat_q;
  assign words[IX_BTN]  = DATA_W'(btn_q);
  assign words[IX_SW]   = DATA_W'(sw_in);
  assign words[IX_RDAT] = rdat_q;
  assign words[IX_MA0]  = ma0_q;
  assign words[IX_MA1]  = ma1_q;

  regfile_rd_mux #(.NREG(N_REGS)) u_mux (
    .rd_sel(rd_sel), .words(words), .rdata(prdata));

  assign pready      = 1'b1;
  assign pslverr     = 1'b0;
  assign cap_ready   = 1'b1;
  assign led_o       = led_q;
  assign btn_flag_o  = btn_q;
  assign mst_addr0_o = ma0_q;
  assign mst_addr1_o = ma1_q;
  assign mst_wdata_o = wdat_q;

  // R2: an unlocked divisor write reaches its output field
  p_div_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && paddr[ADDR_W-1:2] == '0 && !locked)
      |=> (div_cfg_o[DIV_W-1:0] == $past(pwdata[DIV_W-1:0])));

  // R10: unmapped offsets read zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr[ADDR_W-1:2] >= (ADDR_W-2)'(N_REGS)) |-> (prdata == '0));
endmodule

// File: tb/tb_clkcfg_regfile.sv
`timescale 1ns/1ps
module tb_clkcfg_regfile;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata, cap_data = 0;
  logic pready, pslverr, btn_press = 0, cap_valid = 0, cap_ready;
  logic [7:0] sw_in = 0, led_o;
  logic [56:0] div_cfg_o;
  logic btn_flag_o;
  logic [31:0] mst_addr0_o, mst_addr1_o, mst_wdata_o;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  clkcfg_regfile dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    chk("R10 wr pready", {31'b0, pready}, 1);
    chk("R3 wr pslverr", {31'b0, pslverr}, 0);
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin
      rd(8'(4*k), rv); chk("R1 div reset", rv, 32'h2C70);
      chk("R1 div out", 32'(div_cfg_o[k*19 +: 19]), 32'h2C70);
    end
    rd(8'h0C, rv); chk("R1 R4 lock reset", rv, 32'h0001_0000);
    rd(8'h10, rv); chk("R1 led", rv, 0);
    rd(8'h18, rv); chk("R1 btn", rv, 0);
    rd(8'h14, rv); chk("R1 wdat", rv, 0);
    rd(8'h20, rv); chk("R1 rdat", rv, 0);
    rd(8'h24, rv); chk("R8 ma0 reset", rv, 32'h0400_0000);
    rd(8'h28, rv); chk("R8 ma1 reset", rv, 32'h0400_0004);
  endtask

  task automatic t_lock();
    wr(8'h00, 32'h0007_FFFF);
    rd(8'h00, rv); chk("R3 locked write dropped", rv, 32'h2C70);
    chk("R3 out held", 32'(div_cfg_o[18:0]), 32'h2C70);
    wr(8'h0C, 32'hFFFF_A05F);
    rd(8'h0C, rv); chk("R4 unlocked readback", rv, 32'h0000_A05F);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, rv); chk("R2 upper bits zero", rv, 32'h0007_FFFF);
    wr(8'h08, (32'd5 << 16) | (32'h3F << 9) | 32'h1AB);
    chk("R2 div2 field", 32'(div_cfg_o[38 +: 19]), (32'd5 << 16) | (32'h3F << 9) | 32'h1AB);
    wr(8'h0C, 32'h0000_1234);
    rd(8'h0C, rv); chk("R4 relocked", rv, 32'h0001_1234);
    wr(8'h04, 32'h0);
    rd(8'h04, rv); chk("R3 relocked write dropped", rv, 32'h0007_FFFF);
  endtask

  task automatic t_led();
    wr(8'h10, 32'hFFFF_FFA5);
    rd(8'h10, rv); chk("R5 led readback", rv, 32'hA5);
    chk("R5 led_o", 32'(led_o), 32'hA5);
  endtask

  task automatic t_button();
    @(negedge clk); btn_press = 1; @(negedge clk); btn_press = 0;
    chk("R6 press sets", 32'(btn_flag_o), 1);
    wr(8'h18, 0); rd(8'h18, rv); chk("R6 sw clear", rv, 0);
    wr(8'h18, 1); rd(8'h18, rv); chk("R6 sw set", rv, 1);
    wr(8'h18, 0);
    // clear write with a press in its access phase
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 8'h18; pwdata = 0;
    @(negedge clk); penable = 1; btn_press = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; btn_press = 0;
    chk("R6 press beats clear", 32'(btn_flag_o), 1);
  endtask

  task automatic t_switch();
    sw_in = 8'h3C;
    rd(8'h1C, rv); chk("R7 switches", rv, 32'h3C);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, rv); chk("R7 write ignored", rv, 32'h3C);
  endtask

  task automatic t_master();
    wr(8'h24, 32'hDEAD_BEEF); wr(8'h28, 32'h1234_5678); wr(8'h14, 32'hCAFE_0001);
    rd(8'h24, rv); chk("R8 ma0", rv, 32'hDEAD_BEEF);
    rd(8'h28, rv); chk("R8 ma1", rv, 32'h1234_5678);
    chk("R8 ma0 out", mst_addr0_o, 32'hDEAD_BEEF);
    chk("R8 ma1 out", mst_addr1_o, 32'h1234_5678);
    rd(8'h14, rv); chk("R9 wdat", rv, 32'hCAFE_0001);
    chk("R9 wdat out", mst_wdata_o, 32'hCAFE_0001);
  endtask

  task automatic t_capture();
    chk("R11 cap_ready", 32'(cap_ready), 1);
    @(negedge clk); cap_valid = 1; cap_data = 32'h5A5A_0F0F;
    @(negedge clk); cap_valid = 0; cap_data = 32'h0;
    rd(8'h20, rv); chk("R9 captured", rv, 32'h5A5A_0F0F);
    wr(8'h20, 32'h1111_1111);
    rd(8'h20, rv); chk("R9 rdat write ignored", rv, 32'h5A5A_0F0F);
  endtask

  task automatic t_unmapped();
    rd(8'h2C, rv); chk("R10 unmapped 2C", rv, 0);
    rd(8'h3C, rv); chk("R10 unmapped 3C", rv, 0);
    rd(8'hFC, rv); chk("R10 unmapped FC", rv, 0);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_lock(); t_led(); t_button(); t_switch();
    t_master(); t_capture(); t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule